// File: doc/BRIEF.md
# Per-Byte Variable Vector Shifter

This unit shifts a 128-bit vector, seen as sixteen 8-bit bytes, by amounts taken from a second 128-bit operand. Three shift kinds are offered: logical left, logical right and arithmetic right. In per-byte mode each byte moves by its own small amount, from 0 to 7 bits. The bits pushed out of one byte flow into its neighbour instead of being dropped. In uniform mode a single count moves the whole 128-bit quantity, either by bits or by whole bytes.

A caller presents the source vector, the amount vector, a 2-bit operation code, a mode select and a bit/byte select, and pulses a valid strobe. Every result byte is formed from the unmodified source, so a destination that aliases the source needs no staging. With the default configuration the result is registered and appears one clock after the strobe, together with an output valid pulse. The reserved operation code returns the source unchanged and raises an illegal-operation flag.

Top module: `vshift_unit`

## Requirements
- R1: Bytes are numbered 0 to 15, byte 0 holding bits 127..120. In per-byte mode (`per_byte`=1) the amount for byte i is bits 2..0 of byte i of `amt_vec`; bits 7..3 of that byte have no effect.
- R2: Per-byte with `op`=2'b00 (logical left): result byte i is source byte i shifted left, its vacated low bits taken from the top bits of source byte i+1; byte 15 takes zeros.
- R3: Per-byte with `op`=2'b01 (logical right): result byte i is source byte i shifted right, its vacated high bits taken from the low bits of source byte i-1; byte 0 takes zeros.
- R4: Per-byte with `op`=2'b10 (arithmetic right): as R3 for bytes 1 to 15, while byte 0 fills with copies of its own bit 7.
- R5: A per-byte amount of zero yields the source byte unchanged.
- R6: In uniform mode (`per_byte`=0) the count is byte 7 of `amt_vec` (bits 71..64), ANDed with 8'h07 when `byte_units`=0 and with 8'h78 when `byte_units`=1.
- R7: In uniform mode the full 128-bit value shifts as one quantity: `op`=2'b00 left with zero fill, 2'b01 right with zero fill, 2'b10 right with fill from bit 127.
- R8: `op`=2'b11 yields the source vector unchanged with `illegal_op`=1; any other code yields `illegal_op`=0.
- R9: A result is captured on the clock edge where `in_valid`=1 and shown on `res_vec`/`illegal_op` with `res_valid`=1 from that edge until the next; after an edge with `in_valid`=0, `res_valid` is 0 and `res_vec`/`illegal_op` keep their values.
- R10: While `rst_n` is low, `res_vec` is all zeros, `res_valid` is 0 and `illegal_op` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| src_vec | input | 128 | Data vector to shift |
| amt_vec | input | 128 | Shift amounts (per byte) or count (byte 7) |
| op | input | 2 | 00 left logical, 01 right logical, 10 right arithmetic, 11 reserved |
| per_byte | input | 1 | 1 per-byte mode, 0 uniform mode |
| byte_units | input | 1 | Uniform mode: 1 count in whole bytes, 0 in bits |
| res_vec | output | 128 | Shifted result |
| res_valid | output | 1 | Result valid, one clock after the strobe |
| illegal_op | output | 1 | Reserved operation code was used |

## Verification
Every result is due exactly one clock edge after the strobe that carried its operands, so the bench drives operands on the falling edge and compares on the following falling edge, once the capturing rising edge has passed. The model's expectation is formed when the stimulus is driven and held until that compare; on cycles without a strobe it keeps the previous result and expects `res_valid` low, which tests the hold behaviour on every idle clock. Directed cases aim at the edge bytes, the masked amount bits, the sign fill and the reserved code, and a long random run mixes modes, codes and idle cycles.

// File: rtl/vshift_pkg.sv
package vshift_pkg;

  typedef enum logic [1:0] {
    OP_SLL = 2'b00,
    OP_SRL = 2'b01,
    OP_SRA = 2'b10,
    OP_RSV = 2'b11
  } shop_e;

endpackage

// File: rtl/vshift_lane.sv
// One byte lane of the per-byte shifter. hi_nb is the more significant
// neighbour (byte i-1), lo_nb the less significant one (byte i+1).
module vshift_lane
  import vshift_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int AMT_W = $clog2(BYTE_W)
) (
  input  logic [BYTE_W-1:0] cur,
  input  logic [BYTE_W-1:0] hi_nb,
  input  logic [BYTE_W-1:0] lo_nb,
  input  logic [AMT_W-1:0]  amt,
  input  shop_e             op,
  output logic [BYTE_W-1:0] out
);

  logic [2*BYTE_W-1:0] cat_l;
  logic [2*BYTE_W-1:0] cat_r;
  logic [2*BYTE_W-1:0] shl;
  logic [2*BYTE_W-1:0] shr;

  always_comb begin
    cat_l = {cur, lo_nb};
    cat_r = {hi_nb, cur};
    shl   = cat_l << amt;
    shr   = cat_r >> amt;
    unique case (op)
      OP_SLL:          out = shl[2*BYTE_W-1:BYTE_W];
      OP_SRL, OP_SRA:  out = shr[BYTE_W-1:0];
      default:         out = cur;
    endcase
  end

  always_comb begin
    if (amt == '0) begin
      AST_ZERO_AMT_PASS: assert (out == cur); // R5
    end
  end

endmodule

// File: rtl/vshift_whole.sv
// Uniform shift of the full vector by one count.
module vshift_whole
  import vshift_pkg::*;
#(
  parameter int VEC_W = 128,
  localparam int CNT_W = $clog2(VEC_W)
) (
  input  logic [VEC_W-1:0] data,
  input  logic [CNT_W-1:0] cnt,
  input  shop_e            op,
  output logic [VEC_W-1:0] res
);

  logic signed [VEC_W-1:0] sdata;

  always_comb begin
    sdata = $signed(data);
    unique case (op)
      OP_SLL:  res = data << cnt;
      OP_SRL:  res = data >> cnt;
      OP_SRA:  res = VEC_W'(sdata >>> cnt);
      default: res = data;
    endcase
  end

  always_comb begin
    if (op == OP_SLL && cnt != '0) begin
      AST_SLL_LSB_ZERO: assert (res[0] == 1'b0); // R7
    end
    if (op == OP_SRA && data[VEC_W-1]) begin
      AST_SRA_SIGN_KEPT: assert (res[VEC_W-1] == 1'b1); // R7
    end
  end

endmodule

// File: rtl/vshift_unit.sv
module vshift_unit
  import vshift_pkg::*;
#(
  parameter int NBYTES   = 16,
  parameter int BYTE_W   = 8,
  parameter int CNT_BYTE = 7,
  parameter bit REG_OUT  = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [NBYTES*BYTE_W-1:0] src_vec,
  input  logic [NBYTES*BYTE_W-1:0] amt_vec,
  input  logic [1:0]               op,
  input  logic                     per_byte,
  input  logic                     byte_units,
  output logic [NBYTES*BYTE_W-1:0] res_vec,
  output logic                     res_valid,
  output logic                     illegal_op
);

  localparam int VEC_W = NBYTES * BYTE_W;
  localparam int AMT_W = $clog2(BYTE_W);
  localparam int CNT_W = $clog2(VEC_W);
  localparam int CNT_LSB = VEC_W - (CNT_BYTE + 1) * BYTE_W;
  localparam logic [BYTE_W-1:0] BIT_MASK  = BYTE_W'(BYTE_W - 1);
  localparam logic [BYTE_W-1:0] BYTE_MASK = BYTE_W'((VEC_W - 1) & ~(BYTE_W - 1));

  shop_e op_e;
  assign op_e = shop_e'(op);

  // ---------------- per-byte path ----------------
  logic [VEC_W-1:0] lane_res;

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    localparam int HI = VEC_W - 1 - i * BYTE_W;
    logic [BYTE_W-1:0] hi_nb;
    logic [BYTE_W-1:0] lo_nb;

    if (i == 0) begin : g_top
      assign hi_nb = (op_e == OP_SRA) ? {BYTE_W{src_vec[VEC_W-1]}} : '0;
    end else begin : g_mid_hi
      assign hi_nb = src_vec[HI+BYTE_W -: BYTE_W];
    end

    if (i == NBYTES - 1) begin : g_bot
      assign lo_nb = '0;
    end else begin : g_mid_lo
      assign lo_nb = src_vec[HI-BYTE_W -: BYTE_W];
    end

    vshift_lane #(.BYTE_W(BYTE_W)) lane_i (
      .cur   (src_vec[HI -: BYTE_W]),
      .hi_nb (hi_nb),
      .lo_nb (lo_nb),
      .amt   (amt_vec[HI-BYTE_W+AMT_W -: AMT_W]),
      .op    (op_e),
      .out   (lane_res[HI -: BYTE_W])
    );
  end

  // ---------------- uniform path ----------------
  logic [BYTE_W-1:0] cnt_raw;
  logic [BYTE_W-1:0] cnt_msk;
  logic [VEC_W-1:0]  whole_res;

  always_comb begin
    cnt_raw = amt_vec[CNT_LSB +: BYTE_W];
    cnt_msk = cnt_raw & (byte_units ? BYTE_MASK : BIT_MASK);
  end

  vshift_whole #(.VEC_W(VEC_W)) whole_i (
    .data (src_vec),
    .cnt  (cnt_msk[CNT_W-1:0]),
    .op   (op_e),
    .res  (whole_res)
  );

  // ---------------- result select ----------------
  logic [VEC_W-1:0] res_nx;
  logic             ill_nx;

  always_comb begin
    ill_nx = (op_e == OP_RSV);
    if (ill_nx)        res_nx = src_vec;
    else if (per_byte) res_nx = lane_res;
    else               res_nx = whole_res;
  end

  // ---------------- output stage ----------------
  if (REG_OUT) begin : g_reg
    logic [VEC_W-1:0] res_q, res_d;
    logic             ill_q, ill_d;
    logic             vld_q;

    always_comb begin
      res_d = res_q;
      ill_d = ill_q;
      if (in_valid) begin
        res_d = res_nx;
        ill_d = ill_nx;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q <= '0;
        ill_q <= 1'b0;
        vld_q <= 1'b0;
      end else begin
        res_q <= res_d;
        ill_q <= ill_d;
        vld_q <= in_valid;
      end
    end

    assign res_vec    = res_q;
    assign illegal_op = ill_q;
    assign res_valid  = vld_q;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> res_valid); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!res_valid && $stable(res_vec) && $stable(illegal_op))); // R9
    AST_RSV_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 2'b11) |=> (illegal_op && res_vec == $past(src_vec))); // R8
    AST_LEGAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op != 2'b11) |=> !illegal_op); // R8
  end else begin : g_comb
    assign res_vec    = res_nx;
    assign illegal_op = ill_nx;
    assign res_valid  = in_valid;
  end

endmodule

// File: tb/vshift_unit_tb_top.sv
module vshift_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 100000;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] src_vec;
  logic [127:0] amt_vec;
  logic [1:0]   op;
  logic         per_byte;
  logic         byte_units;
  logic [127:0] res_vec;
  logic         res_valid;
  logic         illegal_op;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [127:0] exp_res;
  logic         exp_vld;
  logic         exp_ill;
  string        exp_tag;

  vshift_unit dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .src_vec    (src_vec),
    .amt_vec    (amt_vec),
    .op         (op),
    .per_byte   (per_byte),
    .byte_units (byte_units),
    .res_vec    (res_vec),
    .res_valid  (res_valid),
    .illegal_op (illegal_op)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural model of one operation.
  function automatic logic [127:0] model(logic [127:0] s, logic [127:0] a,
                                         logic [1:0] o, logic pb, logic by);
    logic [127:0] r;
    int b, nb, sh, v, c;
    if (o == 2'b11) return s;
    r = '0;
    if (pb) begin
      for (int i = 0; i < 16; i++) begin
        b  = int'(s[127-8*i -: 8]);
        sh = int'(a[127-8*i -: 8]) % 8;
        if (o == 2'b00) begin
          nb = (i < 15) ? int'(s[119-8*i -: 8]) : 0;
          v  = ((b << sh) | (nb >> (8 - sh))) & 255;
        end else begin
          if (i > 0) nb = int'(s[135-8*i -: 8]);
          else nb = (o == 2'b10 && b >= 128) ? 255 : 0;
          v  = ((b >> sh) | (nb << (8 - sh))) & 255;
        end
        r[127-8*i -: 8] = 8'(v);
      end
    end else begin
      c = int'(a[71:64]) & (by ? 8'h78 : 8'h07);
      case (o)
        2'b00:   r = s << c;
        2'b01:   r = s >> c;
        default: r = $signed(s) >>> c;
      endcase
    end
    return r;
  endfunction

  task automatic compare();
    checks++;
    if (res_valid !== exp_vld || res_vec !== exp_res || illegal_op !== exp_ill) begin
      errors++;
      $display("FAIL %s: got res=%h vld=%b ill=%b, expected res=%h vld=%b ill=%b",
               exp_tag, res_vec, res_valid, illegal_op, exp_res, exp_vld, exp_ill);
    end
  endtask

  // Check the outcome of the previous cycle, then drive the next one.
  task automatic step(logic v, logic [127:0] s, logic [127:0] a, logic [1:0] o,
                      logic pb, logic by, string tag);
    @(negedge clk);
    compare();
    in_valid   = v;
    src_vec    = s;
    amt_vec    = a;
    op         = o;
    per_byte   = pb;
    byte_units = by;
    exp_vld    = v;
    exp_tag    = tag;
    if (v) begin
      exp_res = model(s, a, o, pb, by);
      exp_ill = (o == 2'b11);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; src_vec = '0; amt_vec = '0;
    op = 2'b00; per_byte = 1'b0; byte_units = 1'b0;
    exp_res = '0; exp_vld = 1'b0; exp_ill = 1'b0; exp_tag = "R10 reset";
    repeat (3) @(negedge clk);
    compare(); // R10 reset state while reset is held
    rst_n = 1'b1;

    // R2 left fill from byte i+1, byte 15 zero fill
    step(1, 128'h8142_F00F_AA55_0102_0304_0506_0708_FFFF, {16{8'h03}}, 2'b00, 1, 0, "R2 per-byte left");
    // R1 upper amount bits ignored (F9 -> 1, 0A -> 2)
    step(1, 128'h8142_F00F_AA55_0102_0304_0506_0708_FFFF, {8{16'hF90A}}, 2'b00, 1, 0, "R1 amount masking");
    // R3 logical right, byte 0 zero fill
    step(1, 128'hFF00_8001_1234_5678_9ABC_DEF0_0F0F_C3C3, {16{8'h05}}, 2'b01, 1, 0, "R3 per-byte right logical");
    // R4 arithmetic right, negative byte 0
    step(1, 128'hF100_8001_1234_5678_9ABC_DEF0_0F0F_C3C3, {16{8'h07}}, 2'b10, 1, 0, "R4 per-byte arith negative");
    // R4 arithmetic right, positive byte 0
    step(1, 128'h7100_8001_1234_5678_9ABC_DEF0_0F0F_C3C3, {8{16'h0104}}, 2'b10, 1, 0, "R4 per-byte arith positive");
    // R5 zero amounts pass through, upper bits set
    step(1, 128'hDEAD_BEEF_0123_4567_89AB_CDEF_F0E1_D2C3, {16{8'hF8}}, 2'b01, 1, 0, "R5 zero amount");
    // R6/R7 uniform bit shifts, count byte 7 = 0xFF -> 7
    step(1, 128'h8000_0000_0000_0001_0000_0000_0000_0001, 128'h0000_0000_0000_00FF_0000_0000_0000_0000, 2'b00, 0, 0, "R6 uniform bit left");
    step(1, 128'h8000_0000_0000_0001_0000_0000_0000_0001, 128'h0000_0000_0000_00FF_0000_0000_0000_0000, 2'b10, 0, 0, "R7 uniform arith right");
    // R6 byte mode, 0xFF -> 0x78 = 120
    step(1, 128'hA500_0000_0000_0000_0000_0000_0000_005A, 128'hFFFF_FFFF_FFFF_FFFF_0000_0000_0000_0000, 2'b01, 0, 1, "R6 uniform byte right 120");
    step(1, 128'hA500_0000_0000_0000_0000_0000_0000_005A, 128'h0000_0000_0000_0009_0000_0000_0000_0000, 2'b00, 0, 1, "R6 uniform byte left 8");
    step(1, 128'hA500_0000_0000_0000_0000_0000_0000_005A, 128'h0000_0000_0000_0013_0000_0000_0000_0000, 2'b10, 0, 1, "R7 uniform byte arith 16");
    // R8 reserved code
    step(1, 128'h0123_4567_89AB_CDEF_0123_4567_89AB_CDEF, {16{8'h03}}, 2'b11, 1, 0, "R8 reserved per-byte");
    // R9 idle cycles hold result and flag
    step(0, rnd128(), rnd128(), 2'b00, 1, 0, "R9 idle hold");
    step(0, rnd128(), rnd128(), 2'b01, 0, 1, "R9 idle hold");
    step(1, 128'h0123_4567_89AB_CDEF_0123_4567_89AB_CDEF, {16{8'h03}}, 2'b01, 1, 0, "R8 legal clears flag");
    step(1, rnd128(), rnd128(), 2'b11, 0, 1, "R8 reserved uniform");

    // Random mix over all modes and codes
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] ro;
      logic rpb;
      ro  = 2'($urandom);
      rpb = 1'($urandom);
      step(($urandom % 4) != 0, rnd128(), rnd128(), ro, rpb, 1'($urandom),
           rpb ? (ro == 2'b00 ? "R2 random" : ro == 2'b01 ? "R3 random" :
                  ro == 2'b10 ? "R4 random" : "R8 random")
               : (ro == 2'b11 ? "R8 random" : "R7 random"));
    end
    step(0, '0, '0, 2'b00, 0, 0, "R9 final");
    @(negedge clk);
    compare();

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule